// File: doc/BRIEF.md
# Ethernet PHY Status Indicator Driver

This block produces the five active-low indicator enables of a 10/100 Ethernet transceiver. Each enable drives an open-drain pad, and a low level lights the lamp. Three of the inputs are single-cycle event strobes: transmit, receive and collision. A short strobe would not be visible on a lamp, so each strobe passes through a retriggerable pulse stretcher. The other inputs are status levels: link good, full duplex, good polarity, descrambler lock, disconnect detect and line speed. The block shows these levels directly, after one register stage.

Three configuration inputs change what some indicators mean:
- The transmit indicator can show disconnect detect instead.
- At 10 Mb/s the duplex indicator shows either full duplex or good polarity.
- The collision indicator can show descrambler lock instead.

The block samples the configuration and speed inputs on every clock edge. A change in selection takes effect at the next edge. The outputs are registered, so they have no glitches.

Top module: `phy_led_drv`

## Requirements
- R1: When `rst_n` is low at a clock edge, all five outputs are high (inactive) after that edge. All stretch history is also discarded, so events sampled before or during reset never light an indicator once reset is released.
- R2: Take `cfg_tx_disc` low and a `tx_evt` strobe sampled at edge k. Then `led_tx_n` is low after edges k+1 through k+STRETCH_CYCLES. With no further strobe, it is high after edge k+STRETCH_CYCLES+1.
- R3: A strobe that arrives while a stretch is running reloads that stretch. The indicator stays low continuously until STRETCH_CYCLES edges after the most recent strobe, with no high gap in between.
- R4: With `cfg_tx_disc` high at edge n, `led_tx_n` after edge n equals the inverse of `disc_det` sampled at edge n. The transmit stretcher keeps running underneath and still accepts strobes.
- R5: `led_rx_n` behaves toward `rx_evt` exactly as R2 and R3 describe, using its own independent stretcher.
- R6: After each edge, `led_link_n` is the inverse of `link_ok` sampled at that edge.
- R7: With `spd_100` high at an edge, `led_dpx_n` after that edge is the inverse of `fdx`.
- R8: With `spd_100` low at an edge, `led_dpx_n` after that edge has two cases:
  - If `cfg_pol10` is high, it is the inverse of `pol_ok`.
  - If `cfg_pol10` is low, it is the inverse of `fdx`.
- R9: With `cfg_col_lock` low, `led_col_n` shows `col_evt` stretched as R2 and R3 describe. With `cfg_col_lock` high, it is the inverse of `dscr_lock` sampled at the same edge.
- R10: A change of any select input applies from the very next edge. When a stretched function is selected again while its stretch is still running, the indicator shows the remaining part of that stretch at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_evt | input | 1 | Transmit event strobe |
| rx_evt | input | 1 | Receive event strobe |
| col_evt | input | 1 | Collision event strobe |
| link_ok | input | 1 | Link good level |
| fdx | input | 1 | Full duplex level |
| pol_ok | input | 1 | Good polarity level (10 Mb/s) |
| dscr_lock | input | 1 | Descrambler locked level |
| disc_det | input | 1 | Disconnect detected level |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| cfg_tx_disc | input | 1 | Transmit indicator shows disconnect detect |
| cfg_pol10 | input | 1 | At 10 Mb/s the duplex indicator shows polarity |
| cfg_col_lock | input | 1 | Collision indicator shows descrambler lock |
| led_tx_n | output | 1 | Transmit / disconnect indicator, active low |
| led_rx_n | output | 1 | Receive indicator, active low |
| led_link_n | output | 1 | Link indicator, active low |
| led_dpx_n | output | 1 | Duplex / polarity indicator, active low |
| led_col_n | output | 1 | Collision / lock indicator, active low |

## Verification
Each level-driven indicator is due one edge after its inputs are sampled. A stretched indicator first goes low two edges after its strobe: one edge loads the counter and one edge registers the output. It then stays low for exactly STRETCH_CYCLES edges after the last strobe. The bench changes inputs only on falling edges and compares outputs on the next falling edge, after the rising edge that registered them. It computes expectations from the index of the edge that sampled each strobe, so it never tracks counter values. A sweep through all 512 combinations of the level and select inputs, with pseudo-random strobes, covers every selection path. Directed phases cover the exact stretch width, retriggering, a stretch hidden under disconnect mode and then shown again, and a reset in the middle of a stretch.

// File: rtl/phy_led_pkg.sv
// Package: shared indices and the active-high indicator bundle used
// between the function selector and the output register stage.
package phy_led_pkg;
    localparam int NUM_EVT = 3;
    localparam int EV_TX   = 0;
    localparam int EV_RX   = 1;
    localparam int EV_COL  = 2;

    // Indicator states, active high (1 = lamp should be lit).
    typedef struct packed {
        logic tx;
        logic rx;
        logic link;
        logic dpx;
        logic col;
    } led_on_t;
endpackage

// File: rtl/led_pulse_stretch.sv
// Module: retriggerable pulse stretcher.
// Assumes evt is a strobe synchronous to clk. Every sampled strobe loads the
// counter with STRETCH_CYCLES; active is high while the count is nonzero.
module led_pulse_stretch #(
    parameter int STRETCH_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    output logic active
);
    localparam int CW = $clog2(STRETCH_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYCLES);

    logic [CW-1:0] cnt_q;

    // Load on a strobe, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (evt) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);
endmodule

// File: rtl/led_func_mux.sv
// Module: per-indicator function selection, purely combinational.
// Assumes stretched activity and levels are active high; output is active high.
module led_func_mux
    import phy_led_pkg::*;
(
    input  logic [NUM_EVT-1:0] stretched,
    input  logic               link_ok,
    input  logic               fdx,
    input  logic               pol_ok,
    input  logic               dscr_lock,
    input  logic               disc_det,
    input  logic               spd_100,
    input  logic               cfg_tx_disc,
    input  logic               cfg_pol10,
    input  logic               cfg_col_lock,
    output led_on_t            on
);
    // Choose the meaning of each indicator from speed and configuration.
    always_comb begin
        on.tx   = cfg_tx_disc ? disc_det : stretched[EV_TX];
        on.rx   = stretched[EV_RX];
        on.link = link_ok;
        if (spd_100) begin
            on.dpx = fdx;
        end else begin
            on.dpx = cfg_pol10 ? pol_ok : fdx;
        end
        on.col  = cfg_col_lock ? dscr_lock : stretched[EV_COL];
    end
endmodule

// File: rtl/phy_led_drv.sv
// Module: top of the status indicator driver.
// Stretches the three event strobes, selects each indicator's function,
// and registers the inverted result for open-drain pad enables.
// Assumes all inputs are synchronous to clk.
module phy_led_drv
    import phy_led_pkg::*;
#(
    parameter int STRETCH_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_evt,
    input  logic rx_evt,
    input  logic col_evt,
    input  logic link_ok,
    input  logic fdx,
    input  logic pol_ok,
    input  logic dscr_lock,
    input  logic disc_det,
    input  logic spd_100,
    input  logic cfg_tx_disc,
    input  logic cfg_pol10,
    input  logic cfg_col_lock,
    output logic led_tx_n,
    output logic led_rx_n,
    output logic led_link_n,
    output logic led_dpx_n,
    output logic led_col_n
);
    logic [NUM_EVT-1:0] evt_vec;
    logic [NUM_EVT-1:0] stretched;
    led_on_t            on;
    led_on_t            out_n_q;

    assign evt_vec[EV_TX]  = tx_evt;
    assign evt_vec[EV_RX]  = rx_evt;
    assign evt_vec[EV_COL] = col_evt;

    // One stretcher per event strobe.
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_str
        led_pulse_stretch #(
            .STRETCH_CYCLES(STRETCH_CYCLES)
        ) str_i (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_vec[g]),
            .active(stretched[g])
        );
    end

    led_func_mux mux_i (
        .stretched   (stretched),
        .link_ok     (link_ok),
        .fdx         (fdx),
        .pol_ok      (pol_ok),
        .dscr_lock   (dscr_lock),
        .disc_det    (disc_det),
        .spd_100     (spd_100),
        .cfg_tx_disc (cfg_tx_disc),
        .cfg_pol10   (cfg_pol10),
        .cfg_col_lock(cfg_col_lock),
        .on          (on)
    );

    // Register inverted indicator states; reset forces all lamps off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_n_q <= '1;
        end else begin
            out_n_q <= ~on;
        end
    end

    assign led_tx_n   = out_n_q.tx;
    assign led_rx_n   = out_n_q.rx;
    assign led_link_n = out_n_q.link;
    assign led_dpx_n  = out_n_q.dpx;
    assign led_col_n  = out_n_q.col;
endmodule

// File: rtl/phy_led_drv_chk.sv
// Module: checker for phy_led_drv, attached with bind; only observes ports.
module phy_led_drv_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_evt,
    input logic rx_evt,
    input logic col_evt,
    input logic link_ok,
    input logic fdx,
    input logic pol_ok,
    input logic dscr_lock,
    input logic disc_det,
    input logic spd_100,
    input logic cfg_tx_disc,
    input logic cfg_pol10,
    input logic cfg_col_lock,
    input logic led_tx_n,
    input logic led_rx_n,
    input logic led_link_n,
    input logic led_dpx_n,
    input logic led_col_n
);
    logic rst_lo_q;

    // Remember whether the last edge sampled reset.
    always_ff @(posedge clk) rst_lo_q <= !rst_n;

    // Check outputs after each reset edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_lo_q === 1'b1) begin
            p_reset_idle_r1: assert ({led_tx_n, led_rx_n, led_link_n, led_dpx_n, led_col_n} == 5'b11111)
                else $error("p_reset_idle_r1");
        end
    end

    p_tx_stretch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_evt ##1 !cfg_tx_disc |=> !led_tx_n);

    p_disc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_tx_disc |=> (led_tx_n == !$past(disc_det)));

    p_rx_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt ##1 1'b1 |=> !led_rx_n);

    p_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (led_link_n == !$past(link_ok)));

    p_dpx100_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spd_100 |=> (led_dpx_n == !$past(fdx)));

    p_pol10_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!spd_100 && cfg_pol10) |=> (led_dpx_n == !$past(pol_ok)));

    p_col_stretch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        col_evt ##1 !cfg_col_lock |=> !led_col_n);

    p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_col_lock |=> (led_col_n == !$past(dscr_lock)));
endmodule

bind phy_led_drv phy_led_drv_chk chk_i (.*);

// File: tb/phy_led_drv_tb_top.sv
// Bench: directed phases plus a full sweep of the level and select inputs,
// with expectations derived from the edge index of each sampled strobe.
module phy_led_drv_tb_top;
    localparam int S = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_evt = 0, rx_evt = 0, col_evt = 0;
    logic link_ok = 0, fdx = 0, pol_ok = 0, dscr_lock = 0, disc_det = 0, spd_100 = 0;
    logic cfg_tx_disc = 0, cfg_pol10 = 0, cfg_col_lock = 0;
    logic led_tx_n, led_rx_n, led_link_n, led_dpx_n, led_col_n;

    int n_chk = 0;
    int n_bad = 0;
    int edge_n = 0;
    int last_e [3];
    bit valid_e [3];
    logic e_tx, e_rx, e_link, e_dpx, e_col;
    bit was_rst;
    string phase_tag = "";
    bit done = 0;

    always #2 clk = ~clk;

    phy_led_drv #(.STRETCH_CYCLES(S)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_evt(tx_evt), .rx_evt(rx_evt), .col_evt(col_evt),
        .link_ok(link_ok), .fdx(fdx), .pol_ok(pol_ok), .dscr_lock(dscr_lock),
        .disc_det(disc_det), .spd_100(spd_100),
        .cfg_tx_disc(cfg_tx_disc), .cfg_pol10(cfg_pol10), .cfg_col_lock(cfg_col_lock),
        .led_tx_n(led_tx_n), .led_rx_n(led_rx_n), .led_link_n(led_link_n),
        .led_dpx_n(led_dpx_n), .led_col_n(led_col_n)
    );

    function automatic bit in_window(int idx, int n);
        return valid_e[idx] && (n - last_e[idx] >= 1) && (n - last_e[idx] <= S);
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at edge %0d", tag, act, exp, edge_n);
        end
    endtask

    // One clock: model the sampling edge, then compare on the falling edge.
    task automatic cyc();
        string t_tx, t_rx, t_dpx, t_col;
        @(posedge clk);
        edge_n++;
        was_rst = !rst_n;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) valid_e[i] = 0;
            {e_tx, e_rx, e_link, e_dpx, e_col} = 5'b11111;
        end else begin
            e_tx   = !(cfg_tx_disc ? disc_det : in_window(0, edge_n));
            e_rx   = !in_window(1, edge_n);
            e_link = !link_ok;
            e_dpx  = !(spd_100 ? fdx : (cfg_pol10 ? pol_ok : fdx));
            e_col  = !(cfg_col_lock ? dscr_lock : in_window(2, edge_n));
            if (tx_evt)  begin last_e[0] = edge_n; valid_e[0] = 1; end
            if (rx_evt)  begin last_e[1] = edge_n; valid_e[1] = 1; end
            if (col_evt) begin last_e[2] = edge_n; valid_e[2] = 1; end
        end
        t_tx  = cfg_tx_disc ? "R4" : "R2";
        t_rx  = "R5";
        t_dpx = spd_100 ? "R7" : "R8";
        t_col = "R9";
        if (phase_tag != "") begin
            t_tx = phase_tag; t_rx = phase_tag; t_col = phase_tag;
        end
        @(negedge clk);
        if (was_rst) begin
            chk("R1", {led_tx_n, led_rx_n, led_link_n, led_dpx_n, led_col_n} == 5'b11111, 1'b1);
        end else begin
            chk(t_tx, led_tx_n, e_tx);
            chk(t_rx, led_rx_n, e_rx);
            chk("R6", led_link_n, e_link);
            chk(t_dpx, led_dpx_n, e_dpx);
            chk(t_col, led_col_n, e_col);
        end
    endtask

    task automatic strobe(logic t, logic r, logic c);
        tx_evt = t; rx_evt = r; col_evt = c;
        cyc();
        tx_evt = 0; rx_evt = 0; col_evt = 0;
    endtask

    initial begin
        logic [7:0] lfsr;
        for (int i = 0; i < 3; i++) begin last_e[i] = 0; valid_e[i] = 0; end
        // R1: reset with strobes present.
        repeat (3) strobe(1, 1, 1);
        rst_n = 1;
        repeat (3) cyc();

        // R2 / R5 / R9: isolated strobes, exact width.
        strobe(1, 0, 0); repeat (S + 3) cyc();
        strobe(0, 1, 0); repeat (S + 3) cyc();
        strobe(0, 0, 1); repeat (S + 3) cyc();

        // R3: retriggering before expiry.
        phase_tag = "R3";
        for (int k = 0; k < 4; k++) begin strobe(1, 1, 1); repeat (S - 2) cyc(); end
        repeat (S + 3) cyc();
        phase_tag = "";

        // R10: hide a running stretch under the alternate function, then reveal it.
        phase_tag = "R10";
        strobe(1, 0, 1);
        cfg_tx_disc = 1; cfg_col_lock = 1; disc_det = 0; dscr_lock = 1;
        cyc();
        disc_det = 1; dscr_lock = 0;
        cyc();
        cfg_tx_disc = 0; cfg_col_lock = 0;
        repeat (S + 2) cyc();
        cfg_tx_disc = 1; tx_evt = 1; cyc(); tx_evt = 0;
        cfg_tx_disc = 0; repeat (S + 2) cyc();
        phase_tag = "";

        // R1: reset in the middle of a stretch discards it.
        strobe(1, 1, 1);
        rst_n = 0; cyc(); rst_n = 1;
        repeat (S + 2) cyc();

        // Sweep all 512 level/select combinations with sparse pseudo-random strobes.
        lfsr = 8'hA5;
        for (int v = 0; v < 512; v++) begin
            {link_ok, fdx, pol_ok, dscr_lock, disc_det, spd_100,
             cfg_tx_disc, cfg_pol10, cfg_col_lock} = 9'(v);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tx_evt  = lfsr[0] & lfsr[3];
            rx_evt  = lfsr[1] & lfsr[5];
            col_evt = lfsr[2] & lfsr[6];
            cyc();
            tx_evt = 0; rx_evt = 0; col_evt = 0;
            cyc();
        end
        repeat (S + 2) cyc();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule